// File: doc/BRIEF.md
# Packed 16-bit SIMD Shift Unit

This block shifts every 16-bit lane of a packed register operand by one common amount. It is a combinational datapath with one registered bit. The instruction fields that pick the operation come in already split out: major opcode, funct3, funct7 and the five-bit field that sits in the second-source slot. The result word appears in the same cycle as its inputs. A single sticky flag records whether any saturating shift has ever clipped a lane.

The unit has seven kinds of shift:

- arithmetic right and logical right, each with a rounding variant;
- plain left, which wraps;
- saturating left, which clips;
- a bidirectional saturating shift, whose signed five-bit amount picks the direction. Its right-shift path can also round.

The amount is taken from the low bits of the second register operand or from a four-bit immediate held in the instruction.

The operand width is a parameter. It holds a whole number of 16-bit lanes, normally 32 or 64 bits. The flag is set only when the surrounding pipeline marks the operation as executing. A synchronous clear input returns the flag to zero.

Top module: `packed_shift16`

## Requirements
- R1: The operand is cut into W/16 independent 16-bit lanes. Lane k occupies bits 16k+15 down to 16k. Every lane is shifted by the same amount, and no lane's result depends on another lane.
- R2: An operation is recognised only when the major opcode is 1110111 and funct3 is 000. For any other funct7 or field combination, the result is all zeros and the flag is unaffected.
- R3: The register forms use funct7 as follows: arith right 0101000, rounding arith right 0110000, logical right 0101001, rounding logical right 0110001, left 0101010, saturating left 0110010. Their amount is bits 3:0 of the amount operand. Bit 4 is ignored.
- R4: The immediate forms use funct7 0111000 (arith right), 0111001 (logical right) and 0111010 (left). Bits 3:0 of the five-bit field give the amount. Bit 4 of that field selects the rounding variant (right) or the saturating variant (left).
- R5: Arithmetic right copies the sign bit into the vacated bits. Logical right fills with zeros. Plain left fills with zeros and drops the bits shifted out.
- R6: A rounding right shift by n > 0 adds bit n-1 of the original lane to the shifted value. The addition is computed without overflow, and the low 16 bits are kept. A shift by 0 returns the lane unchanged. For example, 0xFFFF shifted logically right by 1 gives 0x8000.
- R7: A saturating left shift of lane value v by n clips when v·2^n falls outside -32768..32767. A clipped lane becomes 0x8000 if v is negative and 0x7FFF otherwise. A lane that does not clip equals the plain left shift.
- R8: The bidirectional forms use funct7 0101011 (plain) and 0110011 (rounding). Bits 4:0 of the amount operand are read as a two's-complement value s. When s ≥ 0, the lane is shifted left with saturation by s. When s < 0, the lane is shifted arithmetically right by -s, with a magnitude of 16 clamped to 15. The rounding form rounds on the right path.
- R9: The flag is set at a clock edge when the execute input is high and at least one lane clipped in that cycle. Once set, it stays set through later operations of any kind.
- R10: A high clear input makes the flag 0 at the next edge, and it takes priority over a set in the same cycle. Reset also leaves the flag at 0.
- R11: The result is combinational. It reflects the current inputs without waiting for a clock edge, and it does not depend on the execute input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_i | input | 1 | Operation is executing; qualifies the flag update |
| clr_i | input | 1 | Synchronous clear of the saturation flag |
| opc_i | input | 7 | Major opcode field |
| funct3_i | input | 3 | funct3 field |
| funct7_i | input | 7 | funct7 field |
| shf_i | input | 5 | Second-source field: immediate amount plus variant bit |
| src_i | input | W | Packed source operand |
| amt_i | input | 5 | Low five bits of the amount operand |
| res_o | output | W | Packed result |
| sat_o | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with W = 64, which gives four lanes. This is enough to show that lanes differ in sign and magnitude and still do not interact. Clipping in only the top lane or only the bottom lane shows that any single lane can raise the flag. Directed vectors cover the cases that are easy to get wrong:

- rounding of 0xFFFF and 0x7FFF;
- shift by zero;
- the bidirectional amount of -16;
- the edge between clipping and not clipping.

Randomised operations then compare every lane against an integer model on each cycle.

// File: rtl/pshift16_pkg.sv
package pshift16_pkg;

    localparam int LANE_W = 16;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SRA,
        OP_SRA_RND,
        OP_SRL,
        OP_SRL_RND,
        OP_SLL,
        OP_SLL_SAT,
        OP_BIDIR,
        OP_BIDIR_RND
    } shop_e;

    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic              ovf;
    } lane_res_t;

    // Round-off bit of a right shift by n (zero when n is zero).
    function automatic logic round_bit(input logic [LANE_W-1:0] a, input logic [3:0] n);
        logic [3:0] idx;
        idx = n - 4'd1;
        return (n != 4'd0) ? a[idx] : 1'b0;
    endfunction

    function automatic logic [LANE_W-1:0] sra_lane(input logic [LANE_W-1:0] a,
                                                   input logic [3:0] n, input logic rnd);
        logic signed [LANE_W:0] ext;
        logic        [LANE_W:0] sum;
        ext = $signed({a[LANE_W-1], a}) >>> n;
        sum = ext + {{LANE_W{1'b0}}, rnd & round_bit(a, n)};
        return sum[LANE_W-1:0];
    endfunction

    function automatic logic [LANE_W-1:0] srl_lane(input logic [LANE_W-1:0] a,
                                                   input logic [3:0] n, input logic rnd);
        logic [LANE_W:0] sum;
        sum = ({1'b0, a} >> n) + {{LANE_W{1'b0}}, rnd & round_bit(a, n)};
        return sum[LANE_W-1:0];
    endfunction

    function automatic lane_res_t satl_lane(input logic [LANE_W-1:0] a, input logic [3:0] n);
        lane_res_t         r;
        logic [LANE_W-1:0] sh;
        logic [LANE_W-1:0] back;
        sh    = a << n;
        back  = $signed(sh) >>> n;
        r.ovf = (back != a);
        r.val = r.ovf ? (a[LANE_W-1] ? 16'h8000 : 16'h7FFF) : sh;
        return r;
    endfunction

endpackage

// File: rtl/pshift16_decode.sv
module pshift16_decode
    import pshift16_pkg::*;
(
    input  logic        [6:0] opc_i,
    input  logic        [2:0] funct3_i,
    input  logic        [6:0] funct7_i,
    input  logic        [4:0] shf_i,
    input  logic        [4:0] amt_i,
    output shop_e             op_o,
    output logic signed [4:0] amt_o
);
    logic grp;
    assign grp = (opc_i == 7'b1110111) && (funct3_i == 3'b000);

    always_comb begin
        op_o  = OP_NONE;
        amt_o = {1'b0, amt_i[3:0]};
        if (grp) begin
            unique case (funct7_i)
                7'b0101000: op_o = OP_SRA;
                7'b0110000: op_o = OP_SRA_RND;
                7'b0101001: op_o = OP_SRL;
                7'b0110001: op_o = OP_SRL_RND;
                7'b0101010: op_o = OP_SLL;
                7'b0110010: op_o = OP_SLL_SAT;
                7'b0101011: begin op_o = OP_BIDIR;     amt_o = amt_i; end
                7'b0110011: begin op_o = OP_BIDIR_RND; amt_o = amt_i; end
                7'b0111000: begin
                    op_o  = shf_i[4] ? OP_SRA_RND : OP_SRA;
                    amt_o = {1'b0, shf_i[3:0]};
                end
                7'b0111001: begin
                    op_o  = shf_i[4] ? OP_SRL_RND : OP_SRL;
                    amt_o = {1'b0, shf_i[3:0]};
                end
                7'b0111010: begin
                    op_o  = shf_i[4] ? OP_SLL_SAT : OP_SLL;
                    amt_o = {1'b0, shf_i[3:0]};
                end
                default: op_o = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/pshift16_lane.sv
module pshift16_lane
    import pshift16_pkg::*;
(
    input  logic        [LANE_W-1:0] a_i,
    input  shop_e                    op_i,
    input  logic signed [4:0]        amt_i,
    output logic        [LANE_W-1:0] y_o,
    output logic                     ovf_o
);
    logic [3:0] n;
    logic [4:0] mag;
    logic [3:0] n_right;
    lane_res_t  sat;

    assign n       = amt_i[3:0];
    assign mag     = 5'(-amt_i);
    assign n_right = (mag == 5'd16) ? 4'd15 : mag[3:0];
    assign sat     = satl_lane(a_i, n);

    always_comb begin
        y_o   = '0;
        ovf_o = 1'b0;
        unique case (op_i)
            OP_SRA:     y_o = sra_lane(a_i, n, 1'b0);
            OP_SRA_RND: y_o = sra_lane(a_i, n, 1'b1);
            OP_SRL:     y_o = srl_lane(a_i, n, 1'b0);
            OP_SRL_RND: y_o = srl_lane(a_i, n, 1'b1);
            OP_SLL:     y_o = a_i << n;
            OP_SLL_SAT: begin y_o = sat.val; ovf_o = sat.ovf; end
            OP_BIDIR, OP_BIDIR_RND: begin
                if (amt_i[4]) begin
                    y_o = sra_lane(a_i, n_right, op_i == OP_BIDIR_RND);
                end else begin
                    y_o   = sat.val;
                    ovf_o = sat.ovf;
                end
            end
            default: y_o = '0;
        endcase
    end
endmodule

// File: rtl/packed_shift16.sv
module packed_shift16
    import pshift16_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exec_i,
    input  logic            clr_i,
    input  logic [6:0]      opc_i,
    input  logic [2:0]      funct3_i,
    input  logic [6:0]      funct7_i,
    input  logic [4:0]      shf_i,
    input  logic [XLEN-1:0] src_i,
    input  logic [4:0]      amt_i,
    output logic [XLEN-1:0] res_o,
    output logic            sat_o
);
    localparam int LANES = XLEN / LANE_W;

    shop_e             dec_op;
    logic signed [4:0] dec_amt;
    logic [LANES-1:0]  lane_ovf;
    logic              ovf_any;

    pshift16_decode u_dec (
        .opc_i    (opc_i),
        .funct3_i (funct3_i),
        .funct7_i (funct7_i),
        .shf_i    (shf_i),
        .amt_i    (amt_i),
        .op_o     (dec_op),
        .amt_o    (dec_amt)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pshift16_lane u_lane (
            .a_i   (src_i[g*LANE_W +: LANE_W]),
            .op_i  (dec_op),
            .amt_i (dec_amt),
            .y_o   (res_o[g*LANE_W +: LANE_W]),
            .ovf_o (lane_ovf[g])
        );
    end

    assign ovf_any = |lane_ovf;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sat_o <= 1'b0;
        end else if (exec_i && ovf_any) begin
            sat_o <= 1'b1;
        end
    end
endmodule

// File: rtl/packed_shift16_chk.sv
module packed_shift16_chk
    import pshift16_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            exec_i,
    input logic            clr_i,
    input logic [XLEN-1:0] res_o,
    input logic            sat_o,
    input logic            ovf_any,
    input shop_e           dec_op
);
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !sat_o);  // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sat_o && !clr_i) |=> sat_o);  // R9

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        (exec_i && ovf_any && !clr_i) |=> sat_o);  // R9

    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!sat_o && !(exec_i && ovf_any)) |=> !sat_o);  // R9

    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (dec_op == OP_NONE) |-> (res_o == '0));  // R2

    AST_CLIP_ONLY_SAT: assert property (@(posedge clk) disable iff (rst)
        !(dec_op inside {OP_SLL_SAT, OP_BIDIR, OP_BIDIR_RND}) |-> !ovf_any);  // R7
endmodule

bind packed_shift16 packed_shift16_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .exec_i  (exec_i),
    .clr_i   (clr_i),
    .res_o   (res_o),
    .sat_o   (sat_o),
    .ovf_any (ovf_any),
    .dec_op  (dec_op)
);

// File: tb/test_packed_shift16.sv
module test_packed_shift16;
    localparam int XLEN  = 64;
    localparam int LANES = XLEN / 16;

    logic            clk = 1'b0;
    logic            rst;
    logic            exec_i, clr_i;
    logic [6:0]      opc_i;
    logic [2:0]      funct3_i;
    logic [6:0]      funct7_i;
    logic [4:0]      shf_i;
    logic [XLEN-1:0] src_i;
    logic [4:0]      amt_i;
    logic [XLEN-1:0] res_o;
    logic            sat_o;

    int n_cmp  = 0;
    int n_bad  = 0;
    bit model_flag = 0;
    bit done = 0;

    always #2 clk = ~clk;

    packed_shift16 #(.XLEN(XLEN)) i_packed_shift16 (.*);

    // Integer reference for one lane; kind: 0 none,1 sra,2 sra rnd,3 srl,4 srl rnd,
    // 5 sll,6 sat left,7 bidir,8 bidir rnd
    function automatic int ref_lane(int kind, int a, int n, inout bit ov);
        int sa, r, p, m, s;
        sa = (a >= 32768) ? a - 65536 : a;
        r  = 0;
        case (kind)
            1: r = sa >>> n;
            2: r = (sa >>> n) + ((n > 0) ? ((sa >>> (n - 1)) & 1) : 0);
            3: r = a >> n;
            4: r = (a >> n) + ((n > 0) ? ((a >> (n - 1)) & 1) : 0);
            5: r = a << n;
            6: begin
                p = sa * (1 << n);
                if (p > 32767) begin ov = 1; r = 32767; end
                else if (p < -32768) begin ov = 1; r = -32768; end
                else r = p;
            end
            7, 8: begin
                s = n & 31;
                if (s >= 16) s = s - 32;
                if (s >= 0) r = ref_lane(6, a, s, ov);
                else begin
                    m = -s;
                    if (m == 16) m = 15;
                    r = ref_lane((kind == 8) ? 2 : 1, a, m, ov);
                end
            end
            default: r = 0;
        endcase
        return r & 16'hFFFF;
    endfunction

    function automatic void ref_word(output logic [XLEN-1:0] y, output bit ov);
        int kind, n;
        kind = 0;
        n = amt_i[3:0];
        ov = 0;
        if (opc_i == 7'h77 && funct3_i == 3'd0) begin
            case (funct7_i)
                7'h28: kind = 1;
                7'h30: kind = 2;
                7'h29: kind = 3;
                7'h31: kind = 4;
                7'h2A: kind = 5;
                7'h32: kind = 6;
                7'h2B: begin kind = 7; n = amt_i; end
                7'h33: begin kind = 8; n = amt_i; end
                7'h38: begin kind = shf_i[4] ? 2 : 1; n = shf_i[3:0]; end
                7'h39: begin kind = shf_i[4] ? 4 : 3; n = shf_i[3:0]; end
                7'h3A: begin kind = shf_i[4] ? 6 : 5; n = shf_i[3:0]; end
                default: kind = 0;
            endcase
        end
        for (int k = 0; k < LANES; k++)
            y[k*16 +: 16] = 16'(ref_lane(kind, int'(src_i[k*16 +: 16]), n, ov));
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [6:0] f7, input logic [4:0] shf,
                       input logic [XLEN-1:0] a, input logic [4:0] b,
                       input logic ex, input logic clr, input logic [6:0] opc = 7'h77,
                       input logic [2:0] f3 = 3'd0);
        logic [XLEN-1:0] y;
        bit ov;
        @(negedge clk);
        opc_i = opc; funct3_i = f3; funct7_i = f7; shf_i = shf;
        src_i = a; amt_i = b; exec_i = ex; clr_i = clr;
        #1;
        ref_word(y, ov);
        check({tag, " result"}, res_o, y);   // R11: result before any edge
        @(posedge clk);
        if (clr) model_flag = 0;
        else if (ex && ov) model_flag = 1;
        #1;
        check({tag, " flag"}, {{(XLEN-1){1'b0}}, sat_o}, {{(XLEN-1){1'b0}}, model_flag});
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; exec_i = 0; clr_i = 0; opc_i = 0; funct3_i = 0; funct7_i = 0;
        shf_i = 0; src_i = 0; amt_i = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset flag", {{(XLEN-1){1'b0}}, sat_o}, '0);
        check("R2 reset result", res_o, '0);
        @(negedge clk) rst = 0;

        // R1 R5: distinct lanes, arithmetic / logical / left
        run("R5 sra", 7'h28, 5'd0, 64'h8001_7FFF_F000_0123, 5'd4, 1, 0);
        run("R5 srl", 7'h29, 5'd0, 64'h8001_7FFF_F000_0123, 5'd4, 1, 0);
        run("R5 sll", 7'h2A, 5'd0, 64'h8001_7FFF_F000_0123, 5'd4, 1, 0);
        run("R1 lanes", 7'h28, 5'd0, 64'hFFFF_0000_8000_7FFF, 5'd15, 1, 0);
        // R3: bit 4 of amount ignored by register forms
        run("R3 amt bit4", 7'h29, 5'd0, 64'h1234_5678_9ABC_DEF0, 5'b10011, 1, 0);
        // R6: rounding corners
        run("R6 srl rnd FFFF", 7'h31, 5'd0, 64'hFFFF_FFFF_0001_0003, 5'd1, 1, 0);
        run("R6 sra rnd 7FFF", 7'h30, 5'd0, 64'h7FFF_8000_FFFF_0005, 5'd1, 1, 0);
        run("R6 rnd by zero", 7'h30, 5'd0, 64'h7FFF_8000_FFFF_0005, 5'd0, 1, 0);
        // R4: immediate forms
        run("R4 imm sra", 7'h38, 5'b00011, 64'h8000_0007_FFF9_1000, 5'd0, 1, 0);
        run("R4 imm sra rnd", 7'h38, 5'b10011, 64'h8000_0007_FFF9_1000, 5'd0, 1, 0);
        run("R4 imm srl rnd", 7'h39, 5'b11111, 64'hFFFF_C000_4000_0001, 5'd0, 1, 0);
        run("R4 imm sll", 7'h3A, 5'b01000, 64'h00FF_0080_FF80_1234, 5'd0, 1, 0);
        // R7 R9: clip-edge without overflow keeps flag clear
        run("R7 no clip", 7'h32, 5'd0, 64'h3FFF_C000_0001_FFFF, 5'd1, 1, 0);
        // R9: exec low, clipping lane must not set flag
        run("R9 no exec", 7'h32, 5'd0, 64'h0000_0000_0000_4000, 5'd1, 0, 0);
        run("R7 clip top", 7'h32, 5'd0, 64'h4000_0000_0000_0000, 5'd1, 1, 0);
        run("R9 sticky", 7'h2A, 5'd0, 64'h1111_2222_3333_4444, 5'd2, 1, 0);
        run("R10 clear", 7'h29, 5'd0, 64'h1111_2222_3333_4444, 5'd2, 1, 1);
        // R10: clear wins over a simultaneous clip
        run("R10 clear wins", 7'h3A, 5'b11111, 64'h0001_0000_0000_0000, 5'd0, 1, 1);
        run("R7 imm clip low", 7'h3A, 5'b10100, 64'h0000_0000_0000_F700, 5'd0, 1, 0);
        run("R10 clear2", 7'h28, 5'd0, 64'h0, 5'd0, 0, 1);
        // R8: bidirectional
        run("R8 bidir left", 7'h2B, 5'd0, 64'h0FFF_F001_0001_FFFF, 5'd3, 1, 0);
        run("R8 bidir -16", 7'h2B, 5'd0, 64'h8000_7FFF_0100_FFFF, 5'b10000, 1, 0);
        run("R8 bidir rnd -16", 7'h33, 5'd0, 64'h8000_7FFF_4000_FFFF, 5'b10000, 1, 0);
        run("R8 bidir rnd -3", 7'h33, 5'd0, 64'h0004_FFFB_7FFF_000C, 5'b11101, 1, 0);
        run("R8 bidir clip", 7'h33, 5'd0, 64'h0000_0000_8001_0000, 5'd15, 1, 0);
        // R2: unrecognised encodings
        run("R2 bad funct7", 7'h2C, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 1, 1);
        run("R2 bad opcode", 7'h32, 5'd0, 64'h7FFF_7FFF_7FFF_7FFF, 5'd4, 1, 0, 7'h33);
        run("R2 bad funct3", 7'h32, 5'd0, 64'h7FFF_7FFF_7FFF_7FFF, 5'd4, 1, 0, 7'h77, 3'd1);

        // Random sweep across all encodings
        for (int i = 0; i < 400; i++) begin
            logic [6:0] f7s [11] = '{7'h28, 7'h30, 7'h29, 7'h31, 7'h2A, 7'h32,
                                     7'h2B, 7'h33, 7'h38, 7'h39, 7'h3A};
            run("R1 random", f7s[$urandom_range(0, 10)], 5'($urandom),
                {$urandom, $urandom}, 5'($urandom), 1'($urandom),
                ($urandom_range(0, 15) == 0));
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule